// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Arbiter

This block gathers eight interrupt sources for a 16-bit CPU core and tells the core which one to service next. The sources are a system-reset request, a non-maskable input that triggers on a rising edge, three external maskable lines, a timer-overflow request, a serial-port request and a general external line. The serial-port source fires when either the transfer-complete flag or its dedicated external pin is active. Every source has a pending latch. Each maskable source can only compete for service when its own enable bit and the global enable are both set.

The lowest-numbered eligible rank wins. The block drives a request line, the index of the winning rank and the address of the low byte of that rank's vector word. Vector words are packed downwards from the top of the address space, two bytes per rank. The core acknowledges the request it has taken, and that clears only the pending latch of the presented rank.

Top module: `irq_rank_arbiter`

## Requirements
- R1: While reset is asserted and right after it is released, `irq_o` is 0, `src_o` is 0 and `vec_o` is 0xFFFE.
- R2: When `irq_o` is 1, `src_o` holds the lowest rank number among all eligible pending sources.
- R3: `vec_o` equals 0xFFFE minus twice `src_o`, so rank 0 gives 0xFFFE and rank 7 gives 0xFFF0. When `irq_o` is 0, `src_o` is 0 and `vec_o` is 0xFFFE.
- R4: Rank 1 becomes pending on the clock edge after `nmi_i` goes from 0 to 1. If the pin is held high, it does not become pending again after it is acknowledged.
- R5: Ranks 0 and 1 are eligible whenever they are pending, whatever the values of `en_i` and `gie_i`.
- R6: A rank k from 2 to 7 is eligible only while `en_i[k-2]` and `gie_i` are both 1. A masked rank stays pending and is presented once it is enabled.
- R7: `ack_i` sampled high while `irq_o` is 1 clears the pending latch of the rank in `src_o` at that edge. All other pending ranks, and any request for the same rank arriving in that cycle, are kept.
- R8: `ack_i` sampled high while `irq_o` is 0 changes no pending state.
- R9: Rank 6 requests when either `uart_done_i` or `uart_pin_i` is high.
- R10: A level request on rank 0 or ranks 2 to 7 that is high at a clock edge makes that rank pending after the edge. A request that is still high when its rank is acknowledged becomes pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rst_req_i | input | 1 | Rank 0 system-reset request (level) |
| nmi_i | input | 1 | Rank 1 non-maskable input (rising edge) |
| ext_i | input | 3 | Ranks 2, 3 and 4 external requests (bit 0 is rank 2) |
| tmr_ovf_i | input | 1 | Rank 5 timer overflow request |
| uart_done_i | input | 1 | Rank 6 serial transfer complete |
| uart_pin_i | input | 1 | Rank 6 external serial-interrupt pin |
| ei_i | input | 1 | Rank 7 external request |
| en_i | input | 6 | Per-rank enables; bit k-2 enables rank k |
| gie_i | input | 1 | Global enable for ranks 2 to 7 |
| ack_i | input | 1 | Acknowledge of the presented rank |
| irq_o | output | 1 | An eligible source is pending |
| src_o | output | 3 | Index of the winning rank |
| vec_o | output | 16 | Low-byte address of the winning vector word |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume `nmi_i` is low when reset is released, so no edge is lost or counted twice across reset. The stimulus changes inputs only on the falling clock edge and holds `nmi_i` low through reset. It then drives sparse random requests with random enables, global enable and acknowledge, mixed with directed sequences: the non-maskable pin held high across an acknowledge, the two serial sources one at a time, and a masked request that is later released.

// File: rtl/irq_rank_arbiter.sv
module irq_rank_arbiter #(
  parameter int AW = 16,
  parameter logic [AW-1:0] TOP_VEC = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_req_i,
  input  logic          nmi_i,
  input  logic [2:0]    ext_i,
  input  logic          tmr_ovf_i,
  input  logic          uart_done_i,
  input  logic          uart_pin_i,
  input  logic          ei_i,
  input  logic [5:0]    en_i,
  input  logic          gie_i,
  input  logic          ack_i,
  output logic          irq_o,
  output logic [2:0]    src_o,
  output logic [AW-1:0] vec_o
);
  localparam int NS = 8;

  logic          nmi_q;
  logic [NS-1:0] pend, set_v, clr_v, elig;

  assign set_v = {ei_i, uart_done_i | uart_pin_i, tmr_ovf_i, ext_i,
                  nmi_i & ~nmi_q, rst_req_i};

  assign elig = {pend[NS-1:2] & en_i & {(NS-2){gie_i}}, pend[1:0]};

  always_comb begin
    src_o = '0;
    for (int i = NS - 1; i >= 0; i--)
      if (elig[i]) src_o = 3'(i);
  end

  assign irq_o = |elig;
  assign vec_o = TOP_VEC - AW'({src_o, 1'b0});
  assign clr_v = (ack_i && irq_o) ? (NS'(1) << src_o) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      pend  <= '0;
    end else begin
      nmi_q <= nmi_i;
      pend  <= (pend & ~clr_v) | set_v;
    end
  end

  a_r2_no_better_rank: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((elig & ((NS'(1) << src_o) - NS'(1))) == '0));

  a_r3_vec_window: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o[0] == 1'b0 && vec_o >= TOP_VEC - AW'(2*(NS-1))));

  a_r4_nmi_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_i && !nmi_q) |=> pend[1]);

  a_r5_gie_off_only_nm: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !gie_i) |-> (src_o < 3'd2));

  a_r6_enabled_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && src_o >= 3'd2) |-> (gie_i && en_i[src_o - 3'd2]));

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !set_v[src_o]) |=> !pend[$past(src_o)]);

  a_r8_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: tb/irq_rank_arbiter_tb.sv
module irq_rank_arbiter_tb_top;
  logic clk = 0, rst_n = 0;
  logic rst_req = 0, nmi = 0, tmr = 0, ud = 0, up = 0, ei = 0, gie = 0, ack = 0;
  logic [2:0] ext = 0;
  logic [5:0] en = 0;
  logic irq;
  logic [2:0] src;
  logic [15:0] vec;
  int checks = 0, fails = 0;
  logic [7:0] m_pend = 0;
  logic m_nmi_q = 0;

  always #4 clk = ~clk;

  irq_rank_arbiter dut_i (.clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .nmi_i(nmi),
    .ext_i(ext), .tmr_ovf_i(tmr), .uart_done_i(ud), .uart_pin_i(up), .ei_i(ei),
    .en_i(en), .gie_i(gie), .ack_i(ack), .irq_o(irq), .src_o(src), .vec_o(vec));

  function automatic logic [7:0] elig_f(logic [7:0] p, logic [5:0] e, logic g);
    return {p[7:2] & e & {6{g}}, p[1:0]};
  endfunction

  function automatic logic [2:0] win_f(logic [7:0] el);
    for (int i = 0; i < 8; i++) if (el[i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic chk(logic ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    logic [7:0] el, setv, clrv;
    logic [2:0] w;
    #1;
    el = elig_f(m_pend, en, gie);
    w = win_f(el);
    chk(irq === (|el), {tag, " irq"}, 16'(irq), 16'(|el));
    chk(src === w, {tag, " src"}, 16'(src), 16'(w));
    chk(vec === 16'hFFFE - 16'(2 * w), {tag, " vec"}, vec, 16'hFFFE - 16'(2 * w));
    setv = {ei, ud | up, tmr, ext, nmi & ~m_nmi_q, rst_req};
    clrv = (ack && (|el)) ? (8'd1 << w) : 8'd0;
    @(posedge clk);
    m_pend = (m_pend & ~clrv) | setv;
    m_nmi_q = nmi;
    @(negedge clk);
  endtask

  task automatic quiet();
    rst_req = 0; nmi = 0; tmr = 0; ud = 0; up = 0; ei = 0; ext = 0; ack = 0;
  endtask

  task automatic drain();
    quiet(); gie = 1; en = '1;
    for (int i = 0; i < 10; i++) begin ack = 1; tick("R7 drain"); end
    ack = 0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(irq === 0 && src === 0 && vec === 16'hFFFE, "R1 in reset", vec, 16'hFFFE);
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick("R1 after release");

    // R3/R2: each rank alone, then all together
    gie = 1; en = '1;
    for (int r = 0; r < 8; r++) begin
      quiet();
      case (r)
        0: rst_req = 1; 1: nmi = 1; 2: ext = 3'b001; 3: ext = 3'b010;
        4: ext = 3'b100; 5: tmr = 1; 6: ud = 1; default: ei = 1;
      endcase
      tick("R10 raise");
      quiet();
      tick("R3 single rank");
      ack = 1; tick("R7 ack single");
      ack = 0; tick("R7 cleared");
    end
    ext = 3'b111; tmr = 1; ei = 1; ud = 1;
    tick("R2 raise many");
    quiet();
    for (int i = 0; i < 7; i++) begin ack = 1; tick("R2 ordered service"); end
    drain();

    // R4: held NMI does not retrigger
    nmi = 1; tick("R4 edge");
    ack = 1; tick("R4 ack");
    ack = 0; tick("R4 held high no retrigger");
    tick("R4 still idle");
    chk(irq === 0, "R4 no retrigger", 16'(irq), 16'd0);
    nmi = 0; tick("R4 low");
    drain();

    // R9: each serial source alone
    up = 1; tick("R9 pin"); up = 0;
    chk(irq === 1 && src === 3'd6, "R9 pin rank6", 16'(src), 16'd6);
    ack = 1; tick("R9 ack"); ack = 0;
    ud = 1; tick("R9 done"); ud = 0;
    chk(irq === 1 && src === 3'd6, "R9 done rank6", 16'(src), 16'd6);
    drain();

    // R5/R6/R8: masked pending, ack while idle, then release
    gie = 0; en = '0;
    ext = 3'b010; tick("R6 masked raise"); ext = 0;
    chk(irq === 0, "R6 masked no irq", 16'(irq), 16'd0);
    ack = 1; tick("R8 idle ack"); ack = 0;
    nmi = 1; tick("R5 nmi with gie off"); nmi = 0;
    chk(irq === 1 && src === 3'd1, "R5 nmi bypasses masks", 16'(src), 16'd1);
    ack = 1; tick("R5 ack nmi"); ack = 0;
    en = 6'b000010; tick("R6 enable bit only");
    gie = 1; tick("R6 release");
    chk(irq === 1 && src === 3'd3, "R8 pending kept", 16'(src), 16'd3);

    // R7: ack with same-rank re-request and other new request
    ext = 3'b010; tmr = 1; en = '1; ack = 1;
    tick("R7 ack with new requests");
    ack = 0; quiet();
    chk(irq === 1 && src === 3'd3, "R7 re-request kept", 16'(src), 16'd3);
    drain();

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      rst_req = ($urandom % 40) == 0;
      nmi     = ($urandom % 8) == 0;
      ext     = 3'($urandom) & 3'($urandom) & 3'($urandom);
      tmr     = ($urandom % 6) == 0;
      ud      = ($urandom % 8) == 0;
      up      = ($urandom % 8) == 0;
      ei      = ($urandom % 6) == 0;
      if (($urandom % 16) == 0) en = 6'($urandom);
      if (($urandom % 20) == 0) gie = ~gie;
      ack     = ($urandom % 3) == 0;
      tick("R10 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule